// File: doc/BRIEF.md
# Multi-Mode Timer with Compare Swap

This block is a programmable timer counter. It counts up, down or up/down against a period value held in a register. It runs either continuously or as a one-shot that halts itself at its terminal count. On every counting step the new count is compared with a compare register. When the two match, the block can exchange that register with a buffered compare value, so an alternating pair of match points is produced without any further writes.

Counting is controlled by four inputs. `start` resumes counting from the held count. `stop` halts counting and keeps the count. `reload` jumps the count to its starting value and begins counting. `cnt_en` qualifies each counting step. The four event outputs are terminal count, overflow, underflow and compare match. Each is a registered one-cycle pulse that appears together with the count value that raised it. Configuration comes in through a simple synchronous register write port.

Top module: `tmr_core`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at the next edge. The address selects the target: 0 is the period, 1 the compare value, 2 the buffer compare value and 3 the control register. Control bits [1:0] hold the mode (0 up, 1 down, 2 up/down A, 3 up/down B), bit 2 enables the compare swap and bit 3 selects one-shot.
- R2: In up mode, a step from a count below the period adds one. A step from a count at or above the period gives 0, so period A runs A+1 counts.
- R3: In down mode, a step from a nonzero count subtracts one and a step from 0 gives the period. A reload in down mode loads the period.
- R4: In both up/down modes the count is never reloaded at the ends. The direction turns down at or above the period and up at 0, so a period A of at least 1 gives 2*A steps per cycle.
- R5: `tc_o` pulses when a step lands on the terminal value. That value is the period in up mode and 0 in down mode and in up/down A. In up/down B it is both 0 and the period.
- R6: `ovf_o` pulses when a step lands on the period and `unf_o` pulses when a step lands on 0. Each pulse is one cycle long and appears in the same cycle as the new count.
- R7: `cmp_o` pulses when a step lands on the current compare value.
- R8: With the swap enabled, a compare match exchanges the compare and buffer compare registers at the same edge, unless a register write happens in that cycle. In that case the write wins and the swap is skipped.
- R9: In one-shot mode, a step that lands on a terminal value also clears `running_o`. The count then holds until the next start or reload.
- R10: A step happens only while running with `cnt_en` high and with no stop or reload. The priority order is stop, then reload, then start. Stop clears running and keeps the count. Reload sets the count to 0 (or to the period in down mode), sets the direction to up and sets running. Start sets running when the block is idle. Stop, reload and start raise no events.
- R11: Under synchronous reset all registers are zero, the count is 0, the block is stopped and all event outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | W | Write data |
| start | input | 1 | Resume counting |
| stop | input | 1 | Halt counting, keep count |
| reload | input | 1 | Load start value and count |
| cnt_en | input | 1 | Per-cycle count qualifier |
| count_o | output | W | Current count |
| running_o | output | 1 | Counter is running |
| tc_o | output | 1 | Terminal count pulse |
| ovf_o | output | 1 | Reached-period pulse |
| unf_o | output | 1 | Reached-zero pulse |
| cmp_o | output | 1 | Compare match pulse |

## Verification
The assertions assume the period is at least 1 whenever an up/down mode counts. With a period of 0 the reversal rule would move the count above the period. The assertions also assume all control inputs are clean, synchronous levels. The random stimulus only ever writes periods from 1 to 7, in every mode, so both ends of every mode are reached within a few cycles. It writes any register at any time, including during a compare match, so that the rule letting a write beat the swap is exercised.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        TM_UP   = 2'd0,
        TM_DOWN = 2'd1,
        TM_UDA  = 2'd2,
        TM_UDB  = 2'd3
    } tm_mode_e;

    typedef enum logic [1:0] {
        TA_PERIOD = 2'd0,
        TA_CMP    = 2'd1,
        TA_BUF    = 2'd2,
        TA_CTRL   = 2'd3
    } tm_addr_e;

    typedef struct packed {
        logic     one_shot;
        logic     swap_en;
        tm_mode_e mode;
    } tm_ctrl_t;

    typedef struct packed {
        logic tc;
        logic ovf;
        logic unf;
        logic cmp;
    } tm_evt_t;

    function automatic logic tm_is_terminal(tm_mode_e m, logic at_zero, logic at_top);
        case (m)
            TM_UP:   return at_top;
            TM_DOWN: return at_zero;
            TM_UDA:  return at_zero;
            default: return at_zero | at_top;
        endcase
    endfunction

    function automatic logic tm_loads_top(tm_mode_e m);
        return m == TM_DOWN;
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         swap_req,
    output logic [W-1:0] period_q,
    output logic [W-1:0] cmp_q,
    output tm_ctrl_t     ctrl_q
);

    localparam int CW = $bits(tm_ctrl_t);

    logic [W-1:0] buf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '0;
            cmp_q    <= '0;
            buf_q    <= '0;
            ctrl_q   <= '0;
        end else if (wr_en) begin
            case (tm_addr_e'(wr_addr))
                TA_PERIOD: period_q <= wr_data;
                TA_CMP:    cmp_q    <= wr_data;
                TA_BUF:    buf_q    <= wr_data;
                default:   ctrl_q   <= tm_ctrl_t'(wr_data[CW-1:0]);
            endcase
        end else if (swap_req && ctrl_q.swap_en) begin
            cmp_q <= buf_q;
            buf_q <= cmp_q;
        end
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  tm_ctrl_t     ctrl,
    input  logic [W-1:0] period,
    input  logic         start,
    input  logic         stop,
    input  logic         reload,
    input  logic         cnt_en,
    output logic [W-1:0] count_q,
    output logic         running_q,
    output logic         step,
    output logic [W-1:0] nxt
);

    localparam logic [W-1:0] ONE = W'(1);

    logic dir_q;
    logic dir_n;
    logic up_eff;
    logic at_zero;
    logic at_top;
    logic term_n;

    assign at_zero = (count_q == '0);
    assign at_top  = (count_q >= period);
    assign step    = running_q & cnt_en & ~stop & ~reload;

    always_comb begin
        dir_n  = dir_q;
        up_eff = dir_q;
        case (ctrl.mode)
            TM_UP:   nxt = at_top ? '0 : count_q + ONE;
            TM_DOWN: nxt = at_zero ? period : count_q - ONE;
            default: begin
                if (at_zero)     up_eff = 1'b1;
                else if (at_top) up_eff = 1'b0;
                dir_n = up_eff;
                nxt   = up_eff ? count_q + ONE : count_q - ONE;
            end
        endcase
    end

    assign term_n = tm_is_terminal(ctrl.mode, nxt == '0, nxt == period);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q   <= '0;
            dir_q     <= 1'b1;
            running_q <= 1'b0;
        end else if (stop) begin
            running_q <= 1'b0;
        end else if (reload) begin
            count_q   <= tm_loads_top(ctrl.mode) ? period : '0;
            dir_q     <= 1'b1;
            running_q <= 1'b1;
        end else begin
            if (start && !running_q)
                running_q <= 1'b1;
            if (step) begin
                count_q <= nxt;
                dir_q   <= dir_n;
                if (ctrl.one_shot && term_n)
                    running_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tmr_events.sv
module tmr_events
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  tm_ctrl_t     ctrl,
    input  logic         step,
    input  logic [W-1:0] nxt,
    input  logic [W-1:0] period,
    input  logic [W-1:0] cmp_val,
    output logic         hit,
    output tm_evt_t      evt_q
);

    logic    lands_zero;
    logic    lands_top;
    tm_evt_t evt_n;

    assign lands_zero = (nxt == '0);
    assign lands_top  = (nxt == period);
    assign hit        = step & (nxt == cmp_val);

    always_comb begin
        evt_n.tc  = step & tm_is_terminal(ctrl.mode, lands_zero, lands_top);
        evt_n.ovf = step & lands_top;
        evt_n.unf = step & lands_zero;
        evt_n.cmp = hit;
    end

    always_ff @(posedge clk) begin
        if (rst) evt_q <= '0;
        else     evt_q <= evt_n;
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         start,
    input  logic         stop,
    input  logic         reload,
    input  logic         cnt_en,
    output logic [W-1:0] count_o,
    output logic         running_o,
    output logic         tc_o,
    output logic         ovf_o,
    output logic         unf_o,
    output logic         cmp_o
);

    logic [W-1:0] period_q;
    logic [W-1:0] cmp_q;
    tm_ctrl_t     ctrl_q;
    logic         step;
    logic [W-1:0] nxt;
    logic         hit;
    tm_evt_t      evt_q;

    tmr_regs #(.W(W)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .swap_req (hit),
        .period_q (period_q),
        .cmp_q    (cmp_q),
        .ctrl_q   (ctrl_q)
    );

    tmr_counter #(.W(W)) cnt_i (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl_q),
        .period    (period_q),
        .start     (start),
        .stop      (stop),
        .reload    (reload),
        .cnt_en    (cnt_en),
        .count_q   (count_o),
        .running_q (running_o),
        .step      (step),
        .nxt       (nxt)
    );

    tmr_events #(.W(W)) evt_i (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl_q),
        .step    (step),
        .nxt     (nxt),
        .period  (period_q),
        .cmp_val (cmp_q),
        .hit     (hit),
        .evt_q   (evt_q)
    );

    assign tc_o  = evt_q.tc;
    assign ovf_o = evt_q.ovf;
    assign unf_o = evt_q.unf;
    assign cmp_o = evt_q.cmp;

endmodule

// File: rtl/tmr_core_chk.sv
module tmr_core_chk
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         stop,
    input logic         reload,
    input logic         cnt_en,
    input logic [W-1:0] count_o,
    input logic         running_o,
    input logic         tc_o,
    input logic         ovf_o,
    input logic         unf_o,
    input logic         cmp_o,
    input tm_ctrl_t     ctrl_q,
    input logic [W-1:0] period_q,
    input logic [W-1:0] cmp_q
);

    localparam logic [W-1:0] ONE = W'(1);

    // R10: idle and not reloaded means the count holds
    p_idle_holds_r10: assert property (@(posedge clk) disable iff (rst)
        (!running_o && !reload) |=> $stable(count_o));

    // R10: stop wins and keeps the count
    p_stop_halts_r10: assert property (@(posedge clk) disable iff (rst)
        stop |=> (!running_o && $stable(count_o)));

    // R10: reload without stop leaves the block running
    p_reload_runs_r10: assert property (@(posedge clk) disable iff (rst)
        (reload && !stop) |=> running_o);

    // R6: events only follow a counting step
    p_evt_after_step_r6: assert property (@(posedge clk) disable iff (rst)
        (tc_o || ovf_o || unf_o || cmp_o) |-> $past(running_o && cnt_en && !stop && !reload));

    // R6: underflow arrives with a zero count
    p_unf_zero_r6: assert property (@(posedge clk) disable iff (rst)
        unf_o |-> (count_o == '0));

    // R7: compare pulse carries the compared value
    p_cmp_value_r7: assert property (@(posedge clk) disable iff (rst)
        cmp_o |-> (count_o == $past(cmp_q)));

    // R2: up mode increments below the period
    p_up_incr_r2: assert property (@(posedge clk) disable iff (rst)
        (running_o && cnt_en && !stop && !reload && ctrl_q.mode == TM_UP && count_o < period_q)
        |=> (count_o == $past(count_o) + ONE));

    // R9: one-shot terminal count stops the counter
    p_oneshot_stop_r9: assert property (@(posedge clk) disable iff (rst)
        (tc_o && $past(ctrl_q.one_shot)) |-> !running_o);

endmodule

bind tmr_core tmr_core_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .stop      (stop),
    .reload    (reload),
    .cnt_en    (cnt_en),
    .count_o   (count_o),
    .running_o (running_o),
    .tc_o      (tc_o),
    .ovf_o     (ovf_o),
    .unf_o     (unf_o),
    .cmp_o     (cmp_o),
    .ctrl_q    (ctrl_q),
    .period_q  (period_q),
    .cmp_q     (cmp_q)
);

// File: tb/tmr_core_tb_top.sv
module tmr_core_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int WATCHDOG = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         start = 1'b0;
    logic         stop = 1'b0;
    logic         reload = 1'b0;
    logic         cnt_en = 1'b0;
    logic [W-1:0] count_o;
    logic         running_o;
    logic         tc_o, ovf_o, unf_o, cmp_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_core #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .start(start), .stop(stop), .reload(reload), .cnt_en(cnt_en),
        .count_o(count_o), .running_o(running_o),
        .tc_o(tc_o), .ovf_o(ovf_o), .unf_o(unf_o), .cmp_o(cmp_o)
    );

    // Reference model built from the requirements
    logic [W-1:0] m_per, m_cmp, m_buf, m_cnt;
    logic [3:0]   m_ctrl;
    logic         m_dir, m_run, m_tc, m_ovf, m_unf, m_hit;

    function automatic logic is_term(logic [1:0] md, logic z, logic t);
        if (md == 2'd0) return t;
        if (md == 2'd3) return z | t;
        return z;
    endfunction

    always @(posedge clk) begin
        logic         stp, up, dn;
        logic [W-1:0] nx;
        if (rst) begin
            m_per = '0; m_cmp = '0; m_buf = '0; m_cnt = '0; m_ctrl = '0;
            m_dir = 1'b1; m_run = 1'b0;
            m_tc = 0; m_ovf = 0; m_unf = 0; m_hit = 0;
        end else begin
            stp = m_run && cnt_en && !stop && !reload;
            dn  = m_dir;
            if (m_ctrl[1:0] == 2'd0)      nx = (m_cnt >= m_per) ? '0 : m_cnt + 1'b1;
            else if (m_ctrl[1:0] == 2'd1) nx = (m_cnt == '0) ? m_per : m_cnt - 1'b1;
            else begin
                up = (m_cnt == '0) ? 1'b1 : (m_cnt >= m_per) ? 1'b0 : m_dir;
                dn = up;
                nx = up ? m_cnt + 1'b1 : m_cnt - 1'b1;
            end
            m_tc  = stp && is_term(m_ctrl[1:0], nx == '0, nx == m_per);
            m_ovf = stp && (nx == m_per);
            m_unf = stp && (nx == '0);
            m_hit = stp && (nx == m_cmp);
            // counter state
            if (stop) m_run = 1'b0;
            else if (reload) begin
                m_cnt = (m_ctrl[1:0] == 2'd1) ? m_per : '0;
                m_dir = 1'b1; m_run = 1'b1;
            end else begin
                if (start) m_run = 1'b1;
                if (stp) begin
                    m_cnt = nx; m_dir = dn;
                    if (m_ctrl[3] && m_tc) m_run = 1'b0;
                end
            end
            // registers
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_per = wr_data;
                    2'd1: m_cmp = wr_data;
                    2'd2: m_buf = wr_data;
                    default: m_ctrl = wr_data[3:0];
                endcase
            end else if (m_hit && m_ctrl[2]) begin
                nx = m_cmp; m_cmp = m_buf; m_buf = nx;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            string rq;
            rq = (m_ctrl[1:0] == 2'd0) ? "R2 R1 up count" :
                 (m_ctrl[1:0] == 2'd1) ? "R3 R1 down count" : "R4 R1 up/down count";
            chk(count_o == m_cnt, rq, count_o, m_cnt);
            chk(tc_o == m_tc, "R5 terminal count", tc_o, m_tc);
            chk(ovf_o == m_ovf, "R6 overflow", ovf_o, m_ovf);
            chk(unf_o == m_unf, "R6 underflow", unf_o, m_unf);
            chk(cmp_o == m_hit, "R7 R8 compare match", cmp_o, m_hit);
            chk(running_o == m_run, m_ctrl[3] ? "R9 one-shot running" : "R10 running",
                running_o, m_run);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R10: actual %0d expected %0d", cyc, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_reload();
        @(negedge clk); reload = 1'b1;
        @(negedge clk); reload = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd4242));
        idle(3);
        // R11: reset state
        chk(count_o == '0, "R11 reset count", count_o, 0);
        chk({running_o, tc_o, ovf_o, unf_o, cmp_o} == 5'b0, "R11 reset flags",
            {running_o, tc_o, ovf_o, unf_o, cmp_o}, 0);
        rst = 1'b0;
        cnt_en = 1'b1;

        // R2: up mode, period 4
        wr(2'd0, 4); wr(2'd1, 2); wr(2'd3, 0);
        pulse_reload();
        chk(count_o == 0, "R10 reload up", count_o, 0);
        idle(12);
        // R3: down mode reload loads period
        wr(2'd3, 1);
        pulse_reload();
        chk(count_o == 4, "R3 reload down", count_o, 4);
        idle(12);
        // R4 / R5: both up/down variants
        wr(2'd3, 2); pulse_reload(); idle(12);
        wr(2'd3, 3); pulse_reload(); idle(12);
        // R8: swap between 1 and 3
        wr(2'd1, 1); wr(2'd2, 3); wr(2'd3, 4);
        pulse_reload(); idle(16);
        // R9: one-shot up, stops at period and holds
        wr(2'd3, 8); pulse_reload(); idle(10);
        chk(count_o == 4, "R9 one-shot hold count", count_o, 4);
        chk(running_o == 1'b0, "R9 one-shot stopped", running_o, 0);
        pulse_start(); idle(10);
        // R10: stop holds, cnt_en gating
        wr(2'd3, 0); pulse_reload(); idle(2);
        pulse_stop(); idle(4);
        pulse_start();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); cnt_en = i[0];
        end
        cnt_en = 1'b1;

        // Random phase
        for (int i = 0; i < 5000; i++) begin
            int a;
            @(negedge clk);
            start  = ($urandom % 16) == 0;
            stop   = ($urandom % 40) == 0;
            reload = ($urandom % 40) == 0;
            cnt_en = ($urandom % 4) != 0;
            wr_en  = ($urandom % 16) == 0;
            a = $urandom % 4;
            wr_addr = 2'(a);
            if (a == 0)      wr_data = W'(1 + $urandom % 7);
            else if (a == 3) wr_data = W'($urandom % 16);
            else             wr_data = W'($urandom % 9);
        end
        @(negedge clk);
        {start, stop, reload, wr_en} = '0;
        idle(4);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule